// File: doc/BRIEF.md
# Vector RAM Three-Pass Self-Test Controller

This controller tests a vector memory built from several 16-bit RAM devices that share one address and one write-data bus. Each device has its own read port. After a start pulse, the controller runs three passes. Each pass first writes a fixed pattern into every row. It then reads the same rows back and compares each device's read word with the value it expects. The first pass uses all zeros, the second uses all ones, and the third uses a checkerboard in which even rows hold 0x5555 and odd rows hold 0xAAAA.

The controller halts at the first mismatch it finds and reports the result as one 16-bit diagnostic word. The word holds a 2-bit code for the failing pass, the failing row and the lowest-numbered device that miscompared. A clean run ends with the word at zero. The memory port is a plain synchronous RAM port and not a stream, so there is no valid/ready handshake on it. The RAM always returns read data exactly one cycle after a read strobe, and it takes a write on every cycle that the write strobe is high. The done, fail and start pins are plain level and pulse signals.

Top module: `vmem_bist`

## Requirements
- R1: After reset, done_o, fail_o, mem_wr_o and mem_rd_o are 0 and result_o is 0x0000.
- R2: A start pulse taken while idle or finished begins a run. Each pass opens with a write phase that asserts mem_wr_o for exactly ROWS consecutive cycles, at addresses 0, 1, …, ROWS-1 in ascending order.
- R3: In pass one, every write carries 0x0000.
- R4: In pass two, every write carries 0xFFFF.
- R5: In pass three, every write to an even address carries 0x5555 and every write to an odd address carries 0xAAAA.
- R6: After each write phase comes a read phase that strobes mem_rd_o at ascending addresses starting at 0. The word that every device returns on the next cycle is compared with that pass's pattern for that address.
- R7: On the first mismatch, the controller stops issuing reads and writes and sets done_o and fail_o. For a mismatch at row r, the failing pass has issued min(r+2, ROWS) reads in total.
- R8: On a failure, result_o[15:14] is the pass code (1 for zeros, 2 for ones, 3 for checkerboard), result_o[13:6] is the failing row and result_o[5:0] is the lowest device index that miscompared on that row.
- R9: When all three passes complete without a mismatch, done_o is 1, fail_o is 0 and result_o is 0x0000, after exactly ROWS reads in the third pass.
- R10: done_o, fail_o and result_o hold their values until the next start. A start pulse while a run is in progress has no effect.
- R11: mem_wr_o and mem_rd_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that begins a test run |
| done_o | output | 1 | High once a run has finished |
| fail_o | output | 1 | High when the finished run found a mismatch |
| result_o | output | 16 | Diagnostic word: pass code, row, device index |
| mem_wr_o | output | 1 | Write strobe to all devices |
| mem_rd_o | output | 1 | Read strobe to all devices |
| mem_addr_o | output | 8 | Row address shared by all devices |
| mem_wdata_o | output | 16 | Write word broadcast to all devices |
| mem_rdata_i | input | 64 | Read ports of all devices, device i at bits 16i+15:16i |

## Verification
The assertions assume that the RAM answers every read strobe with data on the following cycle. They also assume that start_i is a clean synchronous pulse. The bench's RAM model follows this latency exactly, and it drives start only on the falling edge, including one deliberate start pulse in the middle of a run. Injected faults (stuck-at bits, and a write that aliases into a neighbouring row) change only the data the model stores or returns. They never change its timing, so the handshake the assertions rely on stays intact.

// File: rtl/vmem_bist_pkg.sv
package vmem_bist_pkg;
  localparam int WORD_W = 16;
  localparam int ROW_FW = 8;
  localparam int DEV_FW = 6;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WR, ST_RD, ST_DRAIN, ST_FIN
  } bist_state_t;

  // Pattern for a pass code (1..3) and the row's least significant bit
  function automatic logic [WORD_W-1:0] pat_word(input logic [1:0] pass_code,
                                                 input logic       row_odd);
    case (pass_code)
      2'd2:    pat_word = {WORD_W{1'b1}};
      2'd3:    pat_word = row_odd ? 16'hAAAA : 16'h5555;
      default: pat_word = '0;
    endcase
  endfunction
endpackage

// File: rtl/vmem_bist_pattern.sv
module vmem_bist_pattern
  import vmem_bist_pkg::*;
(
  input  logic [1:0]        pass_code,
  input  logic              row_odd,
  output logic [WORD_W-1:0] word_o
);
  assign word_o = pat_word(pass_code, row_odd);
endmodule

// File: rtl/vmem_bist_cmp.sv
module vmem_bist_cmp
  import vmem_bist_pkg::*;
#(
  parameter int N_DEV = 4
) (
  input  logic [N_DEV*WORD_W-1:0] rdata_i,
  input  logic [WORD_W-1:0]       expect_i,
  output logic                    miss_o,
  output logic [DEV_FW-1:0]       miss_idx_o
);
  logic [N_DEV-1:0] miss_vec;

  for (genvar g = 0; g < N_DEV; g++) begin : g_dev
    assign miss_vec[g] = (rdata_i[g*WORD_W +: WORD_W] != expect_i);
  end

  // lowest device index wins
  always_comb begin
    miss_idx_o = '0;
    for (int i = N_DEV - 1; i >= 0; i--) begin
      if (miss_vec[i]) miss_idx_o = DEV_FW'(i);
    end
  end

  assign miss_o = |miss_vec;
endmodule

// File: rtl/vmem_bist_seq.sv
module vmem_bist_seq
  import vmem_bist_pkg::*;
#(
  parameter int ROWS = 256,
  localparam int AW  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              miss_i,
  input  logic [DEV_FW-1:0] miss_idx_i,
  output logic              wr_o,
  output logic              rd_o,
  output logic [AW-1:0]     addr_o,
  output logic [AW-1:0]     chk_row_o,
  output logic [1:0]        pass_o,
  output logic              done_o,
  output logic              fail_o,
  output logic [WORD_W-1:0] result_o
);
  localparam logic [AW-1:0] LAST = AW'(ROWS - 1);

  bist_state_t st;
  logic [AW-1:0] addr_q, chk_row_q;
  logic [1:0]    pass_q;
  logic          chk_vld_q, fail_q;
  logic [WORD_W-1:0] res_q;
  logic          hit;

  assign hit = chk_vld_q && miss_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      addr_q    <= '0;
      chk_row_q <= '0;
      pass_q    <= 2'd1;
      chk_vld_q <= 1'b0;
      fail_q    <= 1'b0;
      res_q     <= '0;
    end else begin
      chk_vld_q <= (st == ST_RD);
      chk_row_q <= addr_q;
      case (st)
        ST_IDLE, ST_FIN: begin
          if (start_i) begin
            st     <= ST_WR;
            addr_q <= '0;
            pass_q <= 2'd1;
            fail_q <= 1'b0;
            res_q  <= '0;
          end
        end
        ST_WR: begin
          addr_q <= addr_q + 1'b1;
          if (addr_q == LAST) begin
            st     <= ST_RD;
            addr_q <= '0;
          end
        end
        ST_RD, ST_DRAIN: begin
          if (hit) begin
            st     <= ST_FIN;
            fail_q <= 1'b1;
            res_q  <= {pass_q, ROW_FW'(chk_row_q), miss_idx_i};
          end else if (st == ST_RD) begin
            addr_q <= addr_q + 1'b1;
            if (addr_q == LAST) st <= ST_DRAIN;
          end else if (pass_q == 2'd3) begin
            st <= ST_FIN;
          end else begin
            pass_q <= pass_q + 1'b1;
            addr_q <= '0;
            st     <= ST_WR;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign wr_o      = (st == ST_WR);
  assign rd_o      = (st == ST_RD);
  assign addr_o    = addr_q;
  assign chk_row_o = chk_row_q;
  assign pass_o    = pass_q;
  assign done_o    = (st == ST_FIN);
  assign fail_o    = fail_q;
  assign result_o  = res_q;

  // R11
  no_rdwr_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_o && rd_o));
  // R7
  quiet_when_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !wr_o && !rd_o);
  // R2
  wr_addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_o && $past(wr_o) |-> addr_o == $past(addr_o) + 1'b1);
  // R6
  rd_addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_o && $past(rd_o) |-> addr_o == $past(addr_o) + 1'b1);
  // R8
  fail_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && fail_o |-> result_o[15:14] != 2'd0);
  // R9
  clean_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !fail_o |-> result_o == '0);
  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && $past(done_o) && !$past(start_i) |-> $stable(result_o) && $stable(fail_o));
endmodule

// File: rtl/vmem_bist.sv
module vmem_bist
  import vmem_bist_pkg::*;
#(
  parameter int ROWS  = 256,
  parameter int N_DEV = 4,
  localparam int AW   = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  output logic                    done_o,
  output logic                    fail_o,
  output logic [WORD_W-1:0]       result_o,
  output logic                    mem_wr_o,
  output logic                    mem_rd_o,
  output logic [AW-1:0]           mem_addr_o,
  output logic [WORD_W-1:0]       mem_wdata_o,
  input  logic [N_DEV*WORD_W-1:0] mem_rdata_i
);
  logic [1:0]        pass_code;
  logic [AW-1:0]     chk_row;
  logic [WORD_W-1:0] expect_w;
  logic              miss;
  logic [DEV_FW-1:0] miss_idx;

  vmem_bist_seq #(.ROWS(ROWS)) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .miss_i     (miss),
    .miss_idx_i (miss_idx),
    .wr_o       (mem_wr_o),
    .rd_o       (mem_rd_o),
    .addr_o     (mem_addr_o),
    .chk_row_o  (chk_row),
    .pass_o     (pass_code),
    .done_o     (done_o),
    .fail_o     (fail_o),
    .result_o   (result_o)
  );

  vmem_bist_pattern wr_pat_i (
    .pass_code (pass_code),
    .row_odd   (mem_addr_o[0]),
    .word_o    (mem_wdata_o)
  );

  vmem_bist_pattern chk_pat_i (
    .pass_code (pass_code),
    .row_odd   (chk_row[0]),
    .word_o    (expect_w)
  );

  vmem_bist_cmp #(.N_DEV(N_DEV)) cmp_i (
    .rdata_i    (mem_rdata_i),
    .expect_i   (expect_w),
    .miss_o     (miss),
    .miss_idx_o (miss_idx)
  );

  // R8
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && fail_o |-> int'(result_o[5:0]) < N_DEV);
  // R3
  zero_pass_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_o && pass_code == 2'd1 |-> mem_wdata_o == 16'h0000);
endmodule

// File: tb/vmem_bist_tb_top.sv
module vmem_bist_tb_top;
  localparam int ROWS  = 256;
  localparam int N_DEV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic done, fail, mem_wr, mem_rd;
  logic [15:0] result, mem_wdata;
  logic [7:0]  mem_addr;
  logic [N_DEV*16-1:0] mem_rdata = '0;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  vmem_bist #(.ROWS(ROWS), .N_DEV(N_DEV)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .done_o(done), .fail_o(fail), .result_o(result),
    .mem_wr_o(mem_wr), .mem_rd_o(mem_rd), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  // RAM model with fault injection
  logic [15:0] mem [N_DEV][ROWS];
  bit sa1_en, sb1_en, sa0_en, al_en;
  int sa1_dev, sa1_row, sa1_bit, sb1_dev, sb1_row, sb1_bit;
  int sa0_dev, sa0_row, sa0_bit, al_dev, al_row;

  always @(posedge clk) begin
    if (mem_wr) begin
      for (int d = 0; d < N_DEV; d++) begin
        mem[d][mem_addr] = mem_wdata;
        if (al_en && d == al_dev && int'(mem_addr) == al_row + 1) mem[d][al_row] = mem_wdata;
      end
    end
    if (mem_rd) begin
      for (int d = 0; d < N_DEV; d++) begin
        logic [15:0] v;
        v = mem[d][mem_addr];
        if (sa1_en && d == sa1_dev && int'(mem_addr) == sa1_row) v[sa1_bit] = 1'b1;
        if (sb1_en && d == sb1_dev && int'(mem_addr) == sb1_row) v[sb1_bit] = 1'b1;
        if (sa0_en && d == sa0_dev && int'(mem_addr) == sa0_row) v[sa0_bit] = 1'b0;
        mem_rdata[d*16 +: 16] <= v;
      end
    end
  end

  // Bus monitor: pass tracking, order and data of every access
  int mon_pass, mon_idx, rd_cnt, mon_err, done_acc;
  bit last_wr;

  function automatic logic [15:0] exp_pat(int p, int row);
    if (p == 1) return 16'h0000;
    if (p == 2) return 16'hFFFF;
    return (row % 2 == 1) ? 16'hAAAA : 16'h5555;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_wr && mem_rd) mon_err++;                 // R11
      if (done && (mem_wr || mem_rd)) done_acc++;      // R7
      if (mem_wr) begin
        if (!last_wr) begin mon_pass++; mon_idx = 0; end
        if (int'(mem_addr) != mon_idx) mon_err++;      // R2
        if (mem_wdata != exp_pat(mon_pass, mon_idx)) mon_err++; // R3 R4 R5
        mon_idx++;
        last_wr = 1'b1;
      end
      if (mem_rd) begin
        if (last_wr) begin
          if (mon_idx != ROWS) mon_err++;              // R2 count
          mon_idx = 0; rd_cnt = 0;
        end
        if (int'(mem_addr) != mon_idx) mon_err++;      // R6
        mon_idx++; rd_cnt++;
        last_wr = 1'b0;
      end
    end
  end

  task automatic check(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic clear_faults();
    sa1_en = 0; sb1_en = 0; sa0_en = 0; al_en = 0;
  endtask

  // exp_res: expected word; exp_rd: reads in final pass; poke: start pulse mid-run
  task automatic run(logic [15:0] exp_res, int exp_pass, int exp_rd, bit poke, string req);
    int cyc;
    logic [15:0] held;
    mon_pass = 0; mon_idx = 0; rd_cnt = 0; mon_err = 0; done_acc = 0; last_wr = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b0 && fail == 1'b0, "R10", "done/fail cleared by start", {done, fail}, 0);
    cyc = 0;
    while (!done && cyc < 5000) begin
      start = (poke && cyc == 100);
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    check(cyc < 5000, "R2", "watchdog", cyc, 0);
    check(result == exp_res, req, "result word", result, exp_res);
    check(fail == (exp_res != 0), req, "fail flag", fail, exp_res != 0);
    check(mon_pass == exp_pass && rd_cnt == exp_rd, "R7",
          "pass/reads at stop", mon_pass * 1000 + rd_cnt, exp_pass * 1000 + exp_rd);
    held = result;
    repeat (20) @(negedge clk);
    check(done && result == held && done_acc == 0, "R10", "hold after done",
          result, held);
    check(mon_err == 0, "R6", "bus order/data errors", mon_err, 0);
  endtask

  initial begin
    clear_faults();
    repeat (3) @(negedge clk);
    check(!done && !fail && result == 0 && !mem_wr && !mem_rd, "R1", "reset state",
          {done, fail, mem_wr, mem_rd, result}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done && !mem_wr && !mem_rd, "R1", "idle after reset", {done, mem_wr, mem_rd}, 0);

    // R9 clean run, and R10 with a start pulse mid-run
    run(16'h0000, 3, ROWS, 1'b0, "R9");
    run(16'h0000, 3, ROWS, 1'b1, "R10");

    // R3 R8 stuck-at-1: fails zeros pass
    for (int r = 0; r < ROWS; r += 51) begin
      for (int d = 0; d < N_DEV; d++) begin
        clear_faults();
        sa1_en = 1; sa1_dev = d; sa1_row = r; sa1_bit = (r + d) % 16;
        run({2'd1, 8'(r), 6'(d)}, 1, (r + 2 < ROWS) ? r + 2 : ROWS, 1'b0, "R8");
      end
    end
    // R4 stuck-at-0: fails ones pass
    for (int r = 0; r < ROWS; r += 85) begin
      for (int d = 0; d < N_DEV; d++) begin
        clear_faults();
        sa0_en = 1; sa0_dev = d; sa0_row = r; sa0_bit = (3 * r + d) % 16;
        run({2'd2, 8'(r), 6'(d)}, 2, (r + 2 < ROWS) ? r + 2 : ROWS, 1'b0, "R4");
      end
    end
    // R5 aliasing write: only the checkerboard exposes it
    for (int k = 0; k < 3; k++) begin
      for (int d = 0; d < N_DEV; d++) begin
        int r;
        r = (k == 0) ? 0 : (k == 1) ? 100 : 254;
        clear_faults();
        al_en = 1; al_dev = d; al_row = r;
        run({2'd3, 8'(r), 6'(d)}, 3, r + 2, 1'b0, "R5");
      end
    end
    // R8 lowest device on a shared row
    clear_faults();
    sa1_en = 1; sa1_dev = 2; sa1_row = 10; sa1_bit = 4;
    sb1_en = 1; sb1_dev = 1; sb1_row = 10; sb1_bit = 9;
    run({2'd1, 8'd10, 6'd1}, 1, 12, 1'b0, "R8");
    // R7 earliest row wins over higher device index
    clear_faults();
    sa1_en = 1; sa1_dev = 0; sa1_row = 40; sa1_bit = 0;
    sb1_en = 1; sb1_dev = 3; sb1_row = 20; sb1_bit = 15;
    run({2'd1, 8'd20, 6'd3}, 1, 22, 1'b0, "R7");
    clear_faults();
    run(16'h0000, 3, ROWS, 1'b0, "R9");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    errors++;
    checks++;
    $display("FAIL R2 watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule